// File: doc/BRIEF.md
# Three-Phase Square-Wave Generator

This block divides its clock by six and drives three phase lines. In balanced mode the lines are 50% duty square waves spaced 120 degrees apart. In pulse mode they are one-third-duty pulses that never overlap. A 360 Hz clock, for example, gives three 60 Hz phases. Filtering, amplification and power drive belong to downstream circuits.

The core is a three-stage twisted-ring (Johnson) shift counter with six states per cycle. Its raw stage outputs sit 60 degrees apart. The output stage picks two true stage outputs and one inverted stage output, which puts the phases 120 degrees apart. The pulse decoder forms each pulse from two neighbouring balanced phases. A repair term in the counter feedback pulls any state outside the six-state ring back onto it.

The enable input advances the counter by one step per clock while high. The mode select can change at any time; it acts on the outputs in the same cycle and does not disturb the count.

Top module: `tpg_three_phase`

## Requirements
- R1: A synchronous active-low reset clears every counter stage. While reset is held and after it is released, and before the first enabled clock, phase_o is 3'b100 in both modes.
- R2: A clock edge with enable low leaves the counter unchanged. With mode_sel steady, phase_o then keeps its value.
- R3: Call s the number of enabled clocks since reset, taken modulo 6. Each enabled clock moves s to the next of its six values. The rising edges of phase_o[0] are therefore six enabled clocks apart (one sixth of the clock rate).
- R4: Balanced mode is mode_sel = 0. In it, phase_o[i] is high exactly when ((s - (2i+1)) mod 6) < 3, so each line is high for three of every six enabled clocks.
- R5: In balanced mode the rising edges come in the order phase_o[0], phase_o[1], phase_o[2], two enabled clocks apart. This is 120 degrees of the six-clock cycle.
- R6: Pulse mode is mode_sel = 1. In it, phase_o[i] is high exactly when ((s - (2i+1)) mod 6) < 2. Exactly one line is high at any time, and the lines take turns in the order 0, 1, 2.
- R7: A change of mode_sel changes phase_o in the same cycle, with no clock edge needed. It leaves s unchanged.
- R8: The counter stage vector never holds 3'b010 or 3'b101. Its feedback sends either pattern back onto the six-state ring within two clocks, so phase_o always shows one of the six patterns listed in R4 or R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at six times the output frequency |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Advance the counter one step per clock while high |
| mode_sel | input | 1 | 0 = balanced 50% square waves, 1 = non-overlapping pulses |
| phase_o | output | 3 | Phase lines; bit 0 is phase 1, bit 2 is phase 3 |

## Verification
The bench runs three kinds of sequence.

- Long unbroken enabled runs in each mode. Every one of the six count positions is compared, in both modes, with a formula of s. These runs separate a wrong stage-to-phase choice from a wrong pulse decode.
- Runs with enable gated in an irregular pattern and mode_sel toggled while counting. These show whether holds and mode changes disturb the count.
- A separate balanced run that records the enabled-clock index of each rising edge. It checks the two-clock phase spacing and the six-clock period directly. A reset in the middle of a run confirms that the counter returns to its start phase.

// File: rtl/tpg_pkg.sv
// Package: shared constants and the mode type for the three-phase generator.
// Assumes: exactly three output phases, driven from a three-stage ring.
package tpg_pkg;
    localparam int unsigned STAGES = 3;
    localparam int unsigned PHASES = 3;
    localparam int unsigned CYCLE  = 2 * STAGES;

    typedef enum logic {
        MODE_BALANCED = 1'b0,
        MODE_PULSE    = 1'b1
    } mode_e;
endpackage

// File: rtl/tpg_johnson_core.sv
// Module: twisted-ring shift counter with 2*STAGES states per cycle.
// Stage 0 loads the inverse of the last stage; each other stage copies the
// stage before it. Stage 2 holds a repair term: a lone 1 in stage 1 is not
// passed on, which sends unused states back onto the ring.
// Assumes: STAGES >= 3, synchronous active-low reset to all zeros.
module tpg_johnson_core #(
    parameter int unsigned STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [STAGES-1:0] stage_o
);
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    // Next-state for each stage: inverted feedback, plain shift, or repair.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_d[g] = ~stage_q[STAGES-1];
        end else if (g == 2) begin : g_repair
            assign stage_d[g] = stage_q[1] & (stage_q[0] | stage_q[2]);
        end else begin : g_shift
            assign stage_d[g] = stage_q[g-1];
        end
    end

    // State register: clear on reset, step only when advance is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (advance) begin
            stage_q <= stage_d;
        end
    end

    assign stage_o = stage_q;
endmodule

// File: rtl/tpg_phase_select.sv
// Module: maps the 60-degree-spaced stages to 120-degree-spaced phases.
// Phase 1 = stage 0, phase 2 = stage 2, phase 3 = inverted stage 1.
// Assumes: three stages; purely combinational.
module tpg_phase_select (
    input  logic [2:0] stage_i,
    output logic [2:0] balanced_o
);
    // Pick the true or inverted stage that gives each phase its offset.
    always_comb begin
        balanced_o[0] = stage_i[0];
        balanced_o[1] = stage_i[2];
        balanced_o[2] = ~stage_i[1];
    end
endmodule

// File: rtl/tpg_pulse_decode.sv
// Module: turns overlapping 50% phases into non-overlapping pulses.
// A pulse is high while its own phase is high and the next phase is still low.
// Assumes: PHASES balanced inputs, rising edges in index order.
module tpg_pulse_decode #(
    parameter int unsigned PHASES = 3
) (
    input  logic [PHASES-1:0] balanced_i,
    output logic [PHASES-1:0] pulse_o
);
    // Two-input AND per phase against the inverse of its successor.
    for (genvar g = 0; g < PHASES; g++) begin : g_pulse
        localparam int unsigned NEXT = (g + 1) % PHASES;
        assign pulse_o[g] = balanced_i[g] & ~balanced_i[NEXT];
    end
endmodule

// File: rtl/tpg_three_phase.sv
// Module: top of the three-phase generator. It holds the counter, the phase
// mapping, the pulse decoder and the mode output mux.
// Assumes: clock at six times the wanted output rate; mode may change at
// any time and acts on the outputs in the same cycle.
module tpg_three_phase (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       mode_sel,
    output logic [2:0] phase_o
);
    import tpg_pkg::*;

    logic [STAGES-1:0] stage_w;
    logic [PHASES-1:0] balanced_w;
    logic [PHASES-1:0] pulse_w;
    mode_e             mode_w;

    tpg_johnson_core #(
        .STAGES (STAGES)
    ) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (enable),
        .stage_o (stage_w)
    );

    tpg_phase_select i_select (
        .stage_i    (stage_w),
        .balanced_o (balanced_w)
    );

    tpg_pulse_decode #(
        .PHASES (PHASES)
    ) i_decode (
        .balanced_i (balanced_w),
        .pulse_o    (pulse_w)
    );

    // Output mux: choose the square waves or the pulses.
    always_comb begin
        mode_w  = mode_e'(mode_sel);
        phase_o = (mode_w == MODE_PULSE) ? pulse_w : balanced_w;
    end
endmodule

// File: rtl/tpg_three_phase_chk.sv
// Checker: temporal properties of the three-phase generator, bound to the top.
// Assumes: stage vector order is stage 0 in bit 0.
module tpg_three_phase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       mode_sel,
    input logic [2:0] phase_o,
    input logic [2:0] stage
);
    AST_RESET_START: assert property (@(posedge clk)
        !rst_n |=> (stage == 3'b000) && (phase_o == 3'b100)); // R1
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(stage)); // R2
    AST_STEP_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> stage != $past(stage)); // R3
    AST_BALANCED_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |-> ($countones(phase_o) == 1 || $countones(phase_o) == 2)); // R4
    AST_PULSE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |-> $countones(phase_o) == 1); // R6
    AST_NO_BAD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        stage != 3'b010 && stage != 3'b101); // R8
endmodule

bind tpg_three_phase tpg_three_phase_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .mode_sel (mode_sel),
    .phase_o  (phase_o),
    .stage    (stage_w)
);

// File: tb/test_tpg_three_phase.sv
`timescale 1ns/1ps
module test_tpg_three_phase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       mode_sel = 1'b0;
    logic [2:0] phase_o;
    int checks = 0;
    int fails  = 0;
    int s      = 0;

    always #2.5 clk = ~clk;

    tpg_three_phase i_tpg_three_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .mode_sel (mode_sel),
        .phase_o  (phase_o)
    );

    // Expected outputs for count position st, computed from R4 and R6.
    function automatic logic [2:0] model(int st, logic m);
        logic [2:0] e;
        for (int i = 0; i < 3; i++) begin
            int d;
            d = (st - (2 * i + 1) + 12) % 6;
            e[i] = m ? (d < 2) : (d < 3);
        end
        return e;
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b (s=%0d)", req, act, exp, s);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive inputs away from the edge, compare, then advance the model.
    task automatic step(logic en, logic m, string req);
        @(negedge clk);
        enable = en;
        mode_sel = m;
        #1;
        check(req, phase_o, model(s, m));
        @(posedge clk);
        if (en) s = (s + 1) % 6;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        mode_sel = 1'b0;
        #1;
        check("R1", phase_o, 3'b100);
        mode_sel = 1'b1;
        #1;
        check("R1", phase_o, 3'b100);
        rst_n = 1'b1;
        enable = 1'b0;
        s = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int first_rise[3];
        int second_rise0;
        logic [2:0] prev;
        logic [2:0] cur;

        do_reset();

        // R4: balanced mode over four full cycles.
        for (int c = 0; c < 24; c++) step(1'b1, 1'b0, "R4");
        // R6: pulse mode over four full cycles.
        for (int c = 0; c < 24; c++) step(1'b1, 1'b1, "R6");
        // R2: enable gated in an irregular pattern.
        for (int c = 0; c < 30; c++) step((c % 3) != 1, c[2], "R2");
        // R2: long hold, outputs must not move.
        for (int c = 0; c < 5; c++) step(1'b0, 1'b0, "R2");
        // R7: mode toggled every cycle while counting.
        for (int c = 0; c < 18; c++) step(1'b1, c[0], "R7");
        // R8: every balanced pattern must be one of the six ring patterns.
        for (int c = 0; c < 12; c++) step(1'b1, 1'b0, "R8");

        // R1: reset in the middle of a run returns to the start phase.
        for (int c = 0; c < 3; c++) step(1'b1, 1'b0, "R3");
        do_reset();
        step(1'b1, 1'b0, "R1");

        // R5 / R3: rising-edge positions in balanced mode from reset.
        do_reset();
        first_rise = '{-1, -1, -1};
        second_rise0 = -1;
        prev = 3'b100;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            enable = 1'b1;
            mode_sel = 1'b0;
            #1;
            cur = phase_o;
            for (int i = 0; i < 3; i++) begin
                if (cur[i] && !prev[i]) begin
                    if (first_rise[i] < 0) first_rise[i] = c;
                    else if (i == 0 && second_rise0 < 0) second_rise0 = c;
                end
            end
            prev = cur;
            @(posedge clk);
        end
        check_int("R5", first_rise[0], 1);
        check_int("R5", first_rise[1] - first_rise[0], 2);
        check_int("R5", first_rise[2] - first_rise[1], 2);
        check_int("R3", second_rise0 - first_rise[0], 6);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule